// File: doc/BRIEF.md
# LIN-capable asynchronous serial transceiver

This block is a full-duplex asynchronous serial port. One transmit path and one receive path run at the same time and need no help from the host. Both paths run from a shared baud generator. The generator makes one tick every `baud_div + 1` clock cycles, and sixteen ticks make one bit time. Frames idle high. Each frame has one low start bit, then the data bits least significant bit first, then one high stop bit. Characters carry 8 or 9 data bits.

The transmit side accepts characters on a valid/ready stream. It holds one character while the shifter sends the previous one. The same stream can ask for a LIN-style break instead of a character. The receive side oversamples the line and votes on each bit. It delivers characters, each with its own framing-error bit, on a second valid/ready stream backed by a two-entry queue. In 9-bit mode the receive side can drop every character whose ninth bit is clear, so that only address characters reach the host. When a character completes while the queue is full, the block raises a sticky overrun flag and stops storing characters. The host clears the flag with a pulse on `ovr_clear`.

Back-pressure rules are as follows. A transmit handshake occurs in a cycle where `tx_valid` and `tx_ready` are both high. A receive handshake occurs in a cycle where `rx_valid` and `rx_ready` are both high. While `rx_valid` is high and `rx_ready` is low, `rx_data` and `rx_ferr` hold steady. The serial line cannot be stalled, so receive back-pressure shows up as an overrun.

Top module: `lin_sertrx`

## Requirements
- R1: While reset is asserted, `txd` is high, `tx_ready` is high, `rx_valid` is low and `ovr_flag` is low.
- R2: A transmitted character is framed as follows: one low start bit, then the data bits LSB first, then one high stop bit. There are 8 data bits when `nine_bit`=0 and 9 when `nine_bit`=1, with bit 8 sent last. Each bit lasts 16×(`baud_div`+1) cycles, and `txd` idles high.
- R3: The transmitter holds one character while another is shifting. `tx_ready` is high in the cycle the shifter takes the held character, so a second write is accepted exactly one cycle after the first when the line is idle. `tx_ready` is low while the holding stage is full and the shifter is busy.
- R4: A handshake with `tx_break`=1 sends 13 low bit times followed by one high stop bit. `tx_data` is ignored for that item.
- R5: The receiver decodes frames in the format of R2. In 8-bit mode `rx_data[8]` reads 0. Each bit is the majority of three samples at the bit centre, so a single-cycle glitch at the centre does not change the value.
- R6: A low pulse on `rxd` that is shorter than half a bit time is rejected as a false start and delivers nothing.
- R7: The receive queue holds up to two characters, delivered in arrival order. The head stays stable while it is not accepted.
- R8: If a character completes while two characters are held and none is being read in that cycle, `ovr_flag` is set and that character is discarded. While the flag is set, no character is stored, and the held characters stay readable. A one-cycle pulse on `ovr_clear` clears the flag.
- R9: `rx_ferr` is 1 for exactly the character whose stop bit was sampled low. After a low stop bit, the receiver waits for the line to return high before it looks for the next start bit.
- R10: With `nine_bit`=1 and `addr_filter`=1, a received character whose bit 8 is 0 is discarded. With `addr_filter`=0, every character is delivered.
- R11: Transmission and reception proceed at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | 16 | Tick divisor: one oversampling tick every baud_div+1 cycles |
| nine_bit | input | 1 | 1 selects 9 data bits per character |
| addr_filter | input | 1 | In 9-bit mode, deliver only characters whose bit 8 is set |
| tx_valid | input | 1 | Transmit item offered |
| tx_ready | output | 1 | Transmit holding stage can accept |
| tx_data | input | 9 | Character to send (bit 8 used in 9-bit mode) |
| tx_break | input | 1 | Item is a break rather than a character |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_valid | output | 1 | Received character available |
| rx_ready | input | 1 | Consumer takes the head character |
| rx_data | output | 9 | Head character |
| rx_ferr | output | 1 | Head character had a low stop bit |
| ovr_clear | input | 1 | Pulse to clear the overrun flag |
| ovr_flag | output | 1 | Sticky overrun indicator |

## Verification
Two pairs of events can land in the same cycle, and the bench exercises both. The first pair is the transmit holding stage taking a new character and the shifter taking the held one. The bench provokes this by offering two characters back to back on an idle line. It judges the result in two ways. The two accept cycles must be exactly one cycle apart. Both frames must also emerge in order from the line monitor, with the holding stage refusing a third character until the first frame ends. The second pair is a frame shifting out while another frame is arriving. The bench forks a transmit and a receive together and has both scoreboards match.

// File: rtl/lin_sertrx_pkg.sv
package lin_sertrx_pkg;
  localparam int CHAR_W = 9;
  localparam int OSR    = 16;
  localparam int OSR_W  = $clog2(OSR);

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              ferr;
  } rx_char_t;

  typedef enum logic {RX_IDLE, RX_FRAME} rx_state_t;
endpackage

// File: rtl/lin_sertrx_baud.sv
module lin_sertrx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // Ticks are separated by at least one idle cycle unless the divisor is zero
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || div == '0));
endmodule

// File: rtl/lin_sertrx_tx.sv
module lin_sertrx_tx import lin_sertrx_pkg::*; #(
  parameter int BRK_LEN = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              nine_bit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_break,
  output logic              txd
);
  localparam int SH_W  = (BRK_LEN + 1 > CHAR_W + 2) ? BRK_LEN + 1 : CHAR_W + 2;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam logic [OSR_W-1:0] SUB_LAST = OSR_W'(OSR - 1);

  logic              hold_full_q, hold_brk_q;
  logic [CHAR_W-1:0] hold_data_q;
  logic              busy_q;
  logic [SH_W-1:0]   sh_q;
  logic [CNT_W-1:0]  left_q;
  logic [OSR_W-1:0]  sub_q;
  logic              take;

  assign take     = hold_full_q && !busy_q;
  assign in_ready = !hold_full_q || take;
  assign txd      = busy_q ? sh_q[0] : 1'b1;

  // Holding stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full_q <= 1'b0;
      hold_brk_q  <= 1'b0;
      hold_data_q <= '0;
    end else if (in_valid && in_ready) begin
      hold_full_q <= 1'b1;
      hold_brk_q  <= in_break;
      hold_data_q <= in_data;
    end else if (take) begin
      hold_full_q <= 1'b0;
    end
  end

  // Shifter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      sub_q  <= '0;
      if (hold_brk_q) begin
        sh_q   <= SH_W'({1'b1, {BRK_LEN{1'b0}}});
        left_q <= CNT_W'(BRK_LEN + 1);
      end else if (nine_bit) begin
        sh_q   <= SH_W'({1'b1, hold_data_q, 1'b0});
        left_q <= CNT_W'(CHAR_W + 2);
      end else begin
        sh_q   <= SH_W'({1'b1, hold_data_q[CHAR_W-2:0], 1'b0});
        left_q <= CNT_W'(CHAR_W + 1);
      end
    end else if (busy_q && tick) begin
      if (sub_q == SUB_LAST) begin
        sub_q  <= '0;
        sh_q   <= {1'b1, sh_q[SH_W-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assert_accept_fills_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> hold_full_q);

  assert_frame_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q != '0 && left_q <= CNT_W'(SH_W)));
endmodule

// File: rtl/lin_sertrx_rx.sv
module lin_sertrx_rx import lin_sertrx_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              nine_bit,
  input  logic              halt,
  input  logic              rxd,
  output logic              done,
  output logic [CHAR_W-1:0] char_o,
  output logic              ferr_o
);
  localparam int MID = OSR / 2;
  localparam logic [OSR_W-1:0] SUB_LAST = OSR_W'(OSR - 1);
  localparam logic [OSR_W-1:0] S_A = OSR_W'(MID - 1);
  localparam logic [OSR_W-1:0] S_B = OSR_W'(MID);
  localparam logic [OSR_W-1:0] S_C = OSR_W'(MID + 1);

  logic              sy1_q, sy2_q;
  rx_state_t         st_q;
  logic              armed_q;
  logic [OSR_W-1:0]  sub_q;
  logic [3:0]        bitn_q;
  logic [1:0]        smp_q;
  logic [CHAR_W-1:0] sh_q;
  logic              vote;
  logic [3:0]        stop_idx;

  assign vote     = (smp_q[0] & smp_q[1]) | (smp_q[0] & sy2_q) | (smp_q[1] & sy2_q);
  assign stop_idx = nine_bit ? 4'(CHAR_W + 1) : 4'(CHAR_W);
  assign char_o   = nine_bit ? sh_q : {1'b0, sh_q[CHAR_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= 1'b1;
      sy2_q <= 1'b1;
    end else begin
      sy1_q <= rxd;
      sy2_q <= sy1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      armed_q <= 1'b0;
      sub_q   <= '0;
      bitn_q  <= '0;
      smp_q   <= '0;
      sh_q    <= '0;
      done    <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st_q == RX_IDLE) begin
        if (sy2_q) armed_q <= 1'b1;
        if (tick && armed_q && !halt && !sy2_q) begin
          st_q    <= RX_FRAME;
          armed_q <= 1'b0;
          sub_q   <= '0;
          bitn_q  <= '0;
        end
      end else if (tick) begin
        sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
        if (sub_q == S_A) smp_q[0] <= sy2_q;
        if (sub_q == S_B) smp_q[1] <= sy2_q;
        if (sub_q == S_C) begin
          if (bitn_q == '0) begin
            if (vote) st_q <= RX_IDLE;
            else      bitn_q <= 4'd1;
          end else if (bitn_q == stop_idx) begin
            done   <= 1'b1;
            ferr_o <= !vote;
            st_q   <= RX_IDLE;
          end else begin
            sh_q   <= {vote, sh_q[CHAR_W-1:1]};
            bitn_q <= bitn_q + 1'b1;
          end
        end
      end
    end
  end

  // A completed character always comes from an active frame
  assert_done_after_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st_q == RX_IDLE && $past(st_q) == RX_FRAME));
endmodule

// File: rtl/lin_sertrx_rxbuf.sv
module lin_sertrx_rxbuf import lin_sertrx_pkg::*; #(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [CHAR_W-1:0] push_data,
  input  logic              push_ferr,
  input  logic              nine_bit,
  input  logic              addr_filter,
  input  logic              ovr_clear,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_ferr,
  output logic              ovr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] count_q;
  logic accept, pop, full, store, overrun;
  rx_char_t ent_q [DEPTH];
  rx_char_t head;

  assign accept  = push && !ovr && !(nine_bit && addr_filter && !push_data[CHAR_W-1]);
  assign out_valid = (count_q != '0);
  assign pop     = out_valid && out_ready;
  assign full    = (count_q == CNT_W'(DEPTH));
  assign store   = accept && (!full || pop);
  assign overrun = accept && full && !pop;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    rx_char_t e_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) e_q <= '0;
      else if (store && wptr_q == PTR_W'(g)) e_q <= '{data: push_data, ferr: push_ferr};
    end
    assign ent_q[g] = e_q;
  end

  assign head     = ent_q[rptr_q];
  assign out_data = head.data;
  assign out_ferr = head.ferr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      ovr     <= 1'b0;
    end else begin
      if (store) wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
      if (pop)   rptr_q <= (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
      case ({store, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (overrun)        ovr <= 1'b1;
      else if (ovr_clear) ovr <= 1'b0;
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  assert_head_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ferr)));

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clear) |=> ovr);

  assert_no_growth_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> count_q <= $past(count_q));

  assert_filter_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && nine_bit && addr_filter && !push_data[CHAR_W-1]) |=> count_q <= $past(count_q));
endmodule

// File: rtl/lin_sertrx.sv
module lin_sertrx import lin_sertrx_pkg::*; #(
  parameter int DIV_W    = 16,
  parameter int RX_DEPTH = 2,
  parameter int BRK_LEN  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              nine_bit,
  input  logic              addr_filter,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              tx_break,
  output logic              txd,
  input  logic              rxd,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_ferr,
  input  logic              ovr_clear,
  output logic              ovr_flag
);
  logic              tick;
  logic              rx_done, rx_fe;
  logic [CHAR_W-1:0] rx_char;

  lin_sertrx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  lin_sertrx_tx #(.BRK_LEN(BRK_LEN)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .nine_bit(nine_bit),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .in_break(tx_break), .txd(txd)
  );

  lin_sertrx_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .nine_bit(nine_bit),
    .halt(ovr_flag), .rxd(rxd), .done(rx_done), .char_o(rx_char), .ferr_o(rx_fe)
  );

  lin_sertrx_rxbuf #(.DEPTH(RX_DEPTH)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .push(rx_done), .push_data(rx_char),
    .push_ferr(rx_fe), .nine_bit(nine_bit), .addr_filter(addr_filter),
    .ovr_clear(ovr_clear), .out_valid(rx_valid), .out_ready(rx_ready),
    .out_data(rx_data), .out_ferr(rx_ferr), .ovr(ovr_flag)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (txd && !rx_valid && !ovr_flag));
endmodule

// File: tb/test_lin_sertrx.sv
module test_lin_sertrx;
  localparam int DIV = 1;
  localparam int BP  = 16 * (DIV + 1);

  logic       clk = 1'b0;
  logic       rst_n;
  logic [15:0] baud_div;
  logic       nine_bit, addr_filter;
  logic       tx_valid, tx_ready, tx_break, txd;
  logic [8:0] tx_data;
  logic       rxd, rx_valid, rx_ready, rx_ferr;
  logic [8:0] rx_data;
  logic       ovr_clear, ovr_flag;

  int n_run = 0, n_fail = 0, cyc = 0;
  int tx_push_cnt = 0, tx_done_cnt = 0;
  bit finished = 0;
  logic [10:0] exp_tx[$];
  logic [9:0]  exp_rx[$];
  string       exp_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lin_sertrx i_lin_sertrx (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .nine_bit(nine_bit),
    .addr_filter(addr_filter), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_break(tx_break), .txd(txd), .rxd(rxd),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_ferr(rx_ferr), .ovr_clear(ovr_clear), .ovr_flag(ovr_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Driver: transmit stream; pushes expected frame on handshake
  task automatic tx_send(input logic [8:0] d, input logic brk, output int acc);
    tx_data = d; tx_break = brk; tx_valid = 1'b1;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    acc = cyc + 1;
    exp_tx.push_back({brk, nine_bit, d});
    tx_push_cnt++;
    #1;
    tx_valid = 1'b0;
  endtask

  // Driver: serial line into the receiver
  task automatic rx_drive(input logic [8:0] d, input bit nine, input bit stopv,
                          input int glitch_bit, input bit expect_it, input string tag);
    logic [10:0] bits;
    int n;
    n = nine ? 11 : 10;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < (nine ? 9 : 8); i++) bits[i+1] = d[i];
    bits[n-1] = stopv;
    if (expect_it) begin
      exp_rx.push_back({~stopv, nine ? d : {1'b0, d[7:0]}});
      exp_tag.push_back(tag);
    end
    for (int i = 0; i < n; i++) begin
      rxd = bits[i];
      if (i == glitch_bit) begin
        step(BP / 2);
        rxd = ~bits[i];
        step(1);
        rxd = bits[i];
        step(BP / 2 - 1);
      end else begin
        step(BP);
      end
    end
    rxd = 1'b1;
    step(2 * BP);
  endtask

  task automatic wait_rx_drain();
    while (exp_rx.size() != 0) @(posedge clk);
    step(4);
  endtask

  task automatic wait_tx_drain();
    while (tx_done_cnt != tx_push_cnt) @(posedge clk);
    step(BP);
  endtask

  // Monitor: transmit line
  initial begin
    forever begin : tx_mon
      logic [10:0] e;
      logic [13:0] got, expv;
      int nb;
      @(negedge clk);
      if (rst_n === 1'b1 && txd === 1'b0) begin
        if (exp_tx.size() == 0) begin
          chk(1'b0, "R2", "unexpected tx frame", 0, 1);
          e = '0;
        end else begin
          e = exp_tx.pop_front();
        end
        nb = e[10] ? 14 : (e[9] ? 11 : 10);
        if (e[10])     expv = {1'b1, 13'b0};
        else if (e[9]) expv = 14'({1'b1, e[8:0], 1'b0});
        else           expv = 14'({1'b1, e[7:0], 1'b0});
        got = '0;
        repeat (BP / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
          got[i] = txd;
          if (i != nb - 1) repeat (BP) @(negedge clk);
        end
        chk(got == expv, e[10] ? "R4" : "R2", "tx frame bits", int'(got), int'(expv));
        tx_done_cnt++;
      end
    end
  end

  // Monitor: receive stream scoreboard
  initial begin
    forever begin : rx_mon
      logic [9:0] e;
      string t;
      @(negedge clk);
      if (rst_n === 1'b1 && rx_valid && rx_ready) begin
        if (exp_rx.size() == 0) begin
          chk(1'b0, "R10", "unexpected rx char", int'({rx_ferr, rx_data}), 0);
        end else begin
          e = exp_rx.pop_front();
          t = exp_tag.pop_front();
          chk({rx_ferr, rx_data} == e, t, "rx char {ferr,data}",
              int'({rx_ferr, rx_data}), int'(e));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R11", "watchdog expired", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int a1, a2, a3, dmy;
    rst_n = 1'b0; baud_div = 16'(DIV); nine_bit = 1'b0; addr_filter = 1'b0;
    tx_valid = 1'b0; tx_data = '0; tx_break = 1'b0;
    rxd = 1'b1; rx_ready = 1'b1; ovr_clear = 1'b0;
    step(5);
    chk(txd == 1'b1 && tx_ready == 1'b1 && rx_valid == 1'b0 && ovr_flag == 1'b0,
        "R1", "reset state {txd,rdy,vld,ovr}",
        int'({txd, tx_ready, rx_valid, ovr_flag}), 'b1100);
    rst_n = 1'b1;
    step(4);

    // R2/R3: back-to-back characters, hold refill in same cycle as shifter take
    tx_send(9'h0A5, 1'b0, a1);
    tx_send(9'h03C, 1'b0, a2);
    chk(a2 == a1 + 1, "R3", "second accept cycle offset", a2 - a1, 1);
    chk(tx_ready == 1'b0, "R3", "ready low while hold full and busy", int'(tx_ready), 0);
    tx_send(9'h001, 1'b0, a3);
    chk(a3 - a1 >= 9 * BP, "R3", "third accept waits for first frame", a3 - a1, 9 * BP);
    wait_tx_drain();

    // R4: break ignores data, then a normal character
    tx_send(9'h1FF, 1'b1, dmy);
    tx_send(9'h055, 1'b0, dmy);
    wait_tx_drain();

    // R2: 9-bit characters
    nine_bit = 1'b1;
    tx_send(9'h1A3, 1'b0, dmy);
    tx_send(9'h0F0, 1'b0, dmy);
    wait_tx_drain();
    nine_bit = 1'b0;

    // R5: receive patterns
    rx_drive(9'h05A, 1'b0, 1'b1, -1, 1'b1, "R5");
    rx_drive(9'h0C3, 1'b0, 1'b1, -1, 1'b1, "R5");
    rx_drive(9'h000, 1'b0, 1'b1, -1, 1'b1, "R5");
    rx_drive(9'h0FF, 1'b0, 1'b1, -1, 1'b1, "R5");
    rx_drive(9'h00F, 1'b0, 1'b1, 3, 1'b1, "R5");
    rx_drive(9'h0F0, 1'b0, 1'b1, 6, 1'b1, "R5");
    wait_rx_drain();

    // R6: false start
    rxd = 1'b0;
    step(BP / 4);
    rxd = 1'b1;
    step(2 * BP);
    chk(rx_valid == 1'b0, "R6", "no char after short pulse", int'(rx_valid), 0);
    rx_drive(9'h081, 1'b0, 1'b1, -1, 1'b1, "R6");
    wait_rx_drain();

    // R7/R8: two-entry queue and overrun
    rx_ready = 1'b0;
    rx_drive(9'h011, 1'b0, 1'b1, -1, 1'b1, "R7");
    rx_drive(9'h022, 1'b0, 1'b1, -1, 1'b1, "R7");
    chk(rx_valid == 1'b1 && ovr_flag == 1'b0, "R7", "two held, no overrun",
        int'({rx_valid, ovr_flag}), 'b10);
    chk(rx_data == 9'h011, "R7", "head stable while not read", int'(rx_data), 'h11);
    rx_drive(9'h033, 1'b0, 1'b1, -1, 1'b0, "R8");
    chk(ovr_flag == 1'b1, "R8", "overrun set", int'(ovr_flag), 1);
    chk(rx_data == 9'h011, "R8", "held char readable", int'(rx_data), 'h11);
    rx_drive(9'h044, 1'b0, 1'b1, -1, 1'b0, "R8");
    rx_ready = 1'b1;
    wait_rx_drain();
    chk(rx_valid == 1'b0, "R8", "no char stored during overrun", int'(rx_valid), 0);
    chk(ovr_flag == 1'b1, "R8", "flag sticky", int'(ovr_flag), 1);
    ovr_clear = 1'b1;
    step(1);
    ovr_clear = 1'b0;
    step(1);
    chk(ovr_flag == 1'b0, "R8", "flag cleared", int'(ovr_flag), 0);
    rx_drive(9'h055, 1'b0, 1'b1, -1, 1'b1, "R8");
    wait_rx_drain();

    // R9: framing error on one character only
    rx_drive(9'h066, 1'b0, 1'b0, -1, 1'b1, "R9");
    rx_drive(9'h077, 1'b0, 1'b1, -1, 1'b1, "R9");
    wait_rx_drain();

    // R10: address filtering in 9-bit mode
    nine_bit = 1'b1; addr_filter = 1'b1;
    rx_drive(9'h0AB, 1'b1, 1'b1, -1, 1'b0, "R10");
    rx_drive(9'h1CD, 1'b1, 1'b1, -1, 1'b1, "R10");
    rx_drive(9'h012, 1'b1, 1'b1, -1, 1'b0, "R10");
    wait_rx_drain();
    chk(rx_valid == 1'b0, "R10", "non-address chars dropped", int'(rx_valid), 0);
    addr_filter = 1'b0;
    rx_drive(9'h034, 1'b1, 1'b1, -1, 1'b1, "R10");
    rx_drive(9'h1EE, 1'b1, 1'b1, -1, 1'b1, "R10");
    wait_rx_drain();
    nine_bit = 1'b0;

    // R11: simultaneous transmit and receive
    fork
      tx_send(9'h096, 1'b0, dmy);
      rx_drive(9'h069, 1'b0, 1'b1, -1, 1'b1, "R11");
    join
    wait_tx_drain();
    wait_rx_drain();
    chk(exp_tx.size() == 0 && exp_rx.size() == 0, "R11", "scoreboards empty",
        exp_tx.size() + exp_rx.size(), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule